// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

The block gathers up to 64 device interrupt request lines into one global request register and fans them out to four CPUs. Devices set and clear individual request bits through a raise port and a clear port, each carrying a line number. Every CPU has its own enable mask and its own stored pending register, which always holds the request register ANDed with that mask. The block drives a level interrupt per CPU that stays high while any of that CPU's pending bits is set. It also gives a one-cycle post pulse when a pending bit of that CPU rises, and a one-cycle withdraw pulse when one falls. Nothing is reported for a change that leaves the pending bits as they were.

Software reaches the masks and reads the state through a small 64-bit register bus. The register index is the byte address shifted right by six. Only full 64-bit accesses are legal. Any illegal access returns a one-cycle error pulse and changes no state. Pending state is recomputed in the same clock edge as any mask write, device raise or device clear, so all of these can occur together in one cycle.

Top module: `irq_router`

## Requirements
- R1: After reset every mask, pending and request register is zero. The outputs cpu_irq, cpu_post, cpu_drop, bus_rvalid and bus_err are low.
- R2: A legal write (bus_size = 3, meaning 8 bytes) to index 8+c stores bus_wdata as the mask of CPU c. A legal read of index 8+c returns that mask. A read is answered with bus_rvalid high and bus_rdata one cycle after the request, and the data is the state as it was before that clock edge.
- R3: The pending register of CPU c, read at index 12+c, always equals the mask of CPU c ANDed with the request register.
- R4: A device raise of line n sets request bit n, read at index 16, at the next clock edge.
- R5: A device clear of line n clears request bit n when that bit is set. A clear of a bit that is already clear is spurious and changes nothing.
- R6: A raise and a clear in the same cycle are both applied. When they name the same line, the raise wins and the bit ends up set.
- R7: cpu_irq[c] is high exactly while the pending register of CPU c is non-zero, and it changes at the same clock edge as that register.
- R8: cpu_post[c] pulses for one cycle after an edge at which some pending bit of CPU c went from 0 to 1. cpu_drop[c] pulses for one cycle after an edge at which some pending bit went from 1 to 0. Both can pulse together. Neither pulses when CPU c's pending bits did not change, for example when an already-set line is raised again.
- R9: A read of index 0 (control/status) or of indices 1 to 4 (address arbitration) returns zero.
- R10: An access with bus_size other than 3 gives a one-cycle bus_err pulse, no bus_rvalid and no state change.
- R11: A write to a pending register, the request register or indices 0 to 4, and any access to an unmapped index, gives a one-cycle bus_err pulse, no bus_rvalid and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_raise | input | 1 | Raise strobe for a device line |
| dev_raise_line | input | 6 | Line number to raise |
| dev_clear | input | 1 | Clear strobe for a device line |
| dev_clear_line | input | 6 | Line number to clear |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; index = addr >> 6 |
| bus_size | input | 2 | Access size code, log2 of bytes; only 3 is legal |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a legal read |
| bus_rdata | output | 64 | Read data |
| bus_err | output | 1 | One-cycle pulse after an illegal access |
| cpu_irq | output | 4 | Level device interrupt per CPU |
| cpu_post | output | 4 | Pulse: a pending bit of that CPU rose |
| cpu_drop | output | 4 | Pulse: a pending bit of that CPU fell |

## Verification
The collision that matters is a mask write landing in the same cycle as a device raise and a device clear. The clear may name the same line as the raise, or a line the new mask just enabled or removed. The bench creates this directly with a mask change that both adds and removes pending bits in one edge. It also creates it in a long random phase, where all three sources fire freely and independently. A behavioural model applies clear-then-raise and then the new mask, and it is compared every cycle against the level, post and withdraw outputs and against every read response.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam logic [1:0] SIZE_DWORD = 2'd3;

  localparam int IDX_CSR       = 0;
  localparam int IDX_ARB_LAST  = 4;
  localparam int IDX_MASK_BASE = 8;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RD_ZERO,
    ACC_RD_MASK,
    ACC_WR_MASK,
    ACC_RD_PEND,
    ACC_RD_REQ,
    ACC_BAD
  } acc_kind_e;

endpackage

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  output acc_kind_e         kind,
  output logic [CPU_W-1:0]  cpu_sel
);

  localparam int IDX_W     = ADDR_W - 6;
  localparam int PEND_BASE = IDX_MASK_BASE + NUM_CPU;
  localparam int REQ_IDX   = PEND_BASE + NUM_CPU;

  logic [IDX_W-1:0] idx;
  int unsigned      idx_i;

  assign idx   = bus_addr[ADDR_W-1:6];
  assign idx_i = int'(idx);

  always_comb begin
    kind    = ACC_NONE;
    cpu_sel = '0;
    if (bus_valid) begin
      if (bus_size != SIZE_DWORD) begin
        kind = ACC_BAD;
      end else if (idx_i <= IDX_ARB_LAST) begin
        kind = bus_write ? ACC_BAD : ACC_RD_ZERO;
      end else if (idx_i >= IDX_MASK_BASE && idx_i < PEND_BASE) begin
        kind    = bus_write ? ACC_WR_MASK : ACC_RD_MASK;
        cpu_sel = CPU_W'(idx_i - IDX_MASK_BASE);
      end else if (idx_i >= PEND_BASE && idx_i < REQ_IDX) begin
        kind    = bus_write ? ACC_BAD : ACC_RD_PEND;
        cpu_sel = CPU_W'(idx_i - PEND_BASE);
      end else if (idx_i == REQ_IDX) begin
        kind = bus_write ? ACC_BAD : ACC_RD_REQ;
      end else begin
        kind = ACC_BAD;
      end
    end
  end

endmodule

// File: rtl/irq_request_reg.sv
module irq_request_reg #(
  parameter int NUM_LINES = 64,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 raise_en,
  input  logic [LINE_W-1:0]    raise_line,
  input  logic                 clear_en,
  input  logic [LINE_W-1:0]    clear_line,
  output logic [NUM_LINES-1:0] req_q,
  output logic [NUM_LINES-1:0] req_d
);

  logic [NUM_LINES-1:0] raise_vec;
  logic [NUM_LINES-1:0] clear_vec;

  always_comb begin
    raise_vec = '0;
    clear_vec = '0;
    if (raise_en) raise_vec = NUM_LINES'(1) << raise_line;
    if (clear_en) clear_vec = NUM_LINES'(1) << clear_line;
    // clear applies to set bits only (a spurious clear is a no-op); raise wins
    req_d = (req_q & ~clear_vec) | raise_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req_d;
  end

endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int NUM_LINES = 64,
  parameter int DATA_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mask_we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] req_d,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] pend_q,
  output logic                 irq_q,
  output logic                 post_q,
  output logic                 drop_q
);

  logic [NUM_LINES-1:0] mask_d;
  logic [NUM_LINES-1:0] pend_d;

  always_comb begin
    mask_d = mask_we ? wdata[NUM_LINES-1:0] : mask_q;
    pend_d = mask_d & req_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
      post_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
      irq_q  <= |pend_d;
      post_q <= |(pend_d & ~pend_q);
      drop_q <= |(pend_q & ~pend_d);
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU   = 4,
  parameter int NUM_LINES = 64,
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 12,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dev_raise,
  input  logic [LINE_W-1:0]   dev_raise_line,
  input  logic                dev_clear,
  input  logic [LINE_W-1:0]   dev_clear_line,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [1:0]          bus_size,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic                bus_rvalid,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_err,
  output logic [NUM_CPU-1:0]  cpu_irq,
  output logic [NUM_CPU-1:0]  cpu_post,
  output logic [NUM_CPU-1:0]  cpu_drop
);

  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  acc_kind_e                          kind;
  logic [CPU_W-1:0]                   cpu_sel;
  logic [NUM_LINES-1:0]               req_q;
  logic [NUM_LINES-1:0]               req_d;
  logic [NUM_CPU-1:0][NUM_LINES-1:0]  mask_all;
  logic [NUM_CPU-1:0][NUM_LINES-1:0]  pend_all;
  logic [DATA_W-1:0]                  rd_mux;
  logic                               is_read;

  irq_csr_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .CPU_W(CPU_W)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .kind      (kind),
    .cpu_sel   (cpu_sel)
  );

  irq_request_reg #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_req (
    .clk        (clk),
    .rst        (rst),
    .raise_en   (dev_raise),
    .raise_line (dev_raise_line),
    .clear_en   (dev_clear),
    .clear_line (dev_clear_line),
    .req_q      (req_q),
    .req_d      (req_d)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic we;
    assign we = (kind == ACC_WR_MASK) && (cpu_sel == CPU_W'(c));
    irq_cpu_slice #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_slice (
      .clk     (clk),
      .rst     (rst),
      .mask_we (we),
      .wdata   (bus_wdata),
      .req_d   (req_d),
      .mask_q  (mask_all[c]),
      .pend_q  (pend_all[c]),
      .irq_q   (cpu_irq[c]),
      .post_q  (cpu_post[c]),
      .drop_q  (cpu_drop[c])
    );
  end

  always_comb begin
    rd_mux  = '0;
    is_read = 1'b0;
    case (kind)
      ACC_RD_ZERO: is_read = 1'b1;
      ACC_RD_MASK: begin
        is_read = 1'b1;
        rd_mux  = DATA_W'(mask_all[cpu_sel]);
      end
      ACC_RD_PEND: begin
        is_read = 1'b1;
        rd_mux  = DATA_W'(pend_all[cpu_sel]);
      end
      ACC_RD_REQ: begin
        is_read = 1'b1;
        rd_mux  = DATA_W'(req_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= is_read;
      bus_rdata  <= rd_mux;
      bus_err    <= (kind == ACC_BAD);
    end
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CPU   = 4,
  parameter int NUM_LINES = 64,
  parameter int LINE_W    = 6
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               dev_raise,
  input logic [LINE_W-1:0]                  dev_raise_line,
  input logic                               dev_clear,
  input logic [LINE_W-1:0]                  dev_clear_line,
  input logic                               bus_valid,
  input logic [1:0]                         bus_size,
  input logic                               bus_rvalid,
  input logic                               bus_err,
  input logic [NUM_CPU-1:0]                 cpu_irq,
  input logic [NUM_CPU-1:0]                 cpu_post,
  input logic [NUM_CPU-1:0]                 cpu_drop,
  input logic [NUM_CPU-1:0][NUM_LINES-1:0]  mask_all,
  input logic [NUM_CPU-1:0][NUM_LINES-1:0]  pend_all,
  input logic [NUM_LINES-1:0]               req_q
);

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (rst)
    dev_raise |=> req_q[$past(dev_raise_line)]); // R4

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (dev_clear && !(dev_raise && dev_raise_line == dev_clear_line))
      |=> !req_q[$past(dev_clear_line)]); // R5

  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_size != 2'd3) |=> (bus_err && !bus_rvalid)); // R10

  AST_BAD_SIZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_size != 2'd3) |=> $stable(mask_all)); // R10

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_err && bus_rvalid)); // R11

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    AST_PEND_AND: assert property (@(posedge clk) disable iff (rst)
      pend_all[c] == (mask_all[c] & req_q)); // R3

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
      cpu_irq[c] == (|pend_all[c])); // R7

    AST_POST_RISE: assert property (@(posedge clk) disable iff (rst)
      cpu_post[c] |-> (|(pend_all[c] & ~$past(pend_all[c])))); // R8

    AST_DROP_FALL: assert property (@(posedge clk) disable iff (rst)
      cpu_drop[c] |-> (|($past(pend_all[c]) & ~pend_all[c]))); // R8
  end

endmodule

bind irq_router irq_router_chk #(
  .NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES), .LINE_W(LINE_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .dev_raise      (dev_raise),
  .dev_raise_line (dev_raise_line),
  .dev_clear      (dev_clear),
  .dev_clear_line (dev_clear_line),
  .bus_valid      (bus_valid),
  .bus_size       (bus_size),
  .bus_rvalid     (bus_rvalid),
  .bus_err        (bus_err),
  .cpu_irq        (cpu_irq),
  .cpu_post       (cpu_post),
  .cpu_drop       (cpu_drop),
  .mask_all       (mask_all),
  .pend_all       (pend_all),
  .req_q          (req_q)
);

// File: tb/irq_router_test.sv
module irq_router_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dev_raise = 1'b0;
  logic [5:0]  dev_raise_line = '0;
  logic        dev_clear = 1'b0;
  logic [5:0]  dev_clear_line = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_size = 2'd3;
  logic [63:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [63:0] bus_rdata;
  logic        bus_err;
  logic [3:0]  cpu_irq, cpu_post, cpu_drop;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_router uut (
    .clk(clk), .rst(rst),
    .dev_raise(dev_raise), .dev_raise_line(dev_raise_line),
    .dev_clear(dev_clear), .dev_clear_line(dev_clear_line),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .cpu_irq(cpu_irq), .cpu_post(cpu_post), .cpu_drop(cpu_drop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [63:0] m_mask [NCPU];
  logic [63:0] m_pend [NCPU];
  logic [63:0] m_req;
  logic        e_rvalid, e_err;
  logic [63:0] e_rdata;
  logic [3:0]  e_irq, e_post, e_drop;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCPU; c++) begin m_mask[c] = 0; m_pend[c] = 0; end
      m_req = 0; e_rvalid = 0; e_err = 0; e_rdata = 0;
      e_irq = 0; e_post = 0; e_drop = 0;
    end else begin
      int idx;
      logic [63:0] oldp [NCPU];
      idx = int'(bus_addr >> 6);
      e_rvalid = 0; e_err = 0; e_rdata = 0;
      if (bus_valid) begin
        if (bus_size != 2'd3) e_err = 1;
        else if (idx <= 4) begin
          if (bus_write) e_err = 1; else e_rvalid = 1;
        end else if (idx >= 8 && idx < 12) begin
          if (bus_write) m_mask[idx-8] = bus_wdata;
          else begin e_rvalid = 1; e_rdata = m_mask[idx-8]; end
        end else if (idx >= 12 && idx < 16) begin
          if (bus_write) e_err = 1;
          else begin e_rvalid = 1; e_rdata = m_pend[idx-12]; end
        end else if (idx == 16) begin
          if (bus_write) e_err = 1;
          else begin e_rvalid = 1; e_rdata = m_req; end
        end else e_err = 1;
      end
      if (dev_clear && m_req[dev_clear_line]) m_req[dev_clear_line] = 1'b0;
      if (dev_raise) m_req[dev_raise_line] = 1'b1;
      for (int c = 0; c < NCPU; c++) begin
        oldp[c]   = m_pend[c];
        m_pend[c] = m_mask[c] & m_req;
        e_irq[c]  = (m_pend[c] != 0);
        e_post[c] = ((m_pend[c] & ~oldp[c]) != 0);
        e_drop[c] = ((oldp[c] & ~m_pend[c]) != 0);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 cpu_irq", {60'd0, cpu_irq}, {60'd0, e_irq});
      chk("R8 cpu_post", {60'd0, cpu_post}, {60'd0, e_post});
      chk("R8 cpu_drop", {60'd0, cpu_drop}, {60'd0, e_drop});
      chk("R10 R11 bus_err", {63'd0, bus_err}, {63'd0, e_err});
      chk("R2 bus_rvalid", {63'd0, bus_rvalid}, {63'd0, e_rvalid});
      if (e_rvalid) chk("R2 bus_rdata", bus_rdata, e_rdata);
    end
  end

  logic [63:0] cap_rdata;
  logic        cap_rvalid, cap_err;
  logic [3:0]  cap_irq, cap_post, cap_drop;

  // one cycle of stimulus; entered and left at a falling edge
  task automatic step(input logic bv, input logic bw, input int idx, input logic [1:0] sz,
                      input logic [63:0] wd, input logic rv, input int rl,
                      input logic cv, input int cl);
    bus_valid = bv; bus_write = bw; bus_addr = 12'(idx << 6); bus_size = sz;
    bus_wdata = wd; dev_raise = rv; dev_raise_line = 6'(rl);
    dev_clear = cv; dev_clear_line = 6'(cl);
    @(negedge clk);
    cap_rdata = bus_rdata; cap_rvalid = bus_rvalid; cap_err = bus_err;
    cap_irq = cpu_irq; cap_post = cpu_post; cap_drop = cpu_drop;
    bus_valid = 0; dev_raise = 0; dev_clear = 0;
  endtask

  task automatic rd(input int idx, input logic [63:0] exp, input string tag);
    step(1, 0, idx, 2'd3, 0, 0, 0, 0, 0);
    chk(tag, cap_rdata, exp);
  endtask

  task automatic wr(input int idx, input logic [63:0] d);
    step(1, 1, idx, 2'd3, d, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 outputs after reset", {cpu_irq, cpu_post, cpu_drop, bus_rvalid, bus_err}, 0);
    rd(8, 0, "R1 mask0 reset");
    rd(16, 0, "R1 request reset");
    rd(12, 0, "R1 pending0 reset");

    wr(8, 64'hF0); wr(9, 64'h0F); wr(10, '1); wr(11, 0);
    rd(8, 64'hF0, "R2 mask0 readback");
    rd(10, '1, "R2 mask2 readback");

    step(0, 0, 0, 3, 0, 1, 4, 0, 0);
    chk("R7 irq after raise 4", {60'd0, cap_irq}, 64'b0101);
    rd(16, 64'h10, "R4 request after raise");
    rd(12, 64'h10, "R3 pending0");
    rd(13, 0, "R3 pending1");

    step(0, 0, 0, 3, 0, 0, 0, 1, 9);
    rd(16, 64'h10, "R5 spurious clear");
    step(0, 0, 0, 3, 0, 0, 0, 1, 4);
    rd(16, 0, "R5 clear of set line");
    step(0, 0, 0, 3, 0, 1, 4, 0, 0);

    step(0, 0, 0, 3, 0, 1, 63, 0, 0);
    rd(14, 64'h8000_0000_0000_0010, "R3 pending2 high line");

    step(0, 0, 0, 3, 0, 1, 2, 1, 2);
    rd(16, 64'h8000_0000_0000_0014, "R6 raise wins same line");
    step(0, 0, 0, 3, 0, 1, 7, 1, 4);
    rd(16, 64'h8000_0000_0000_0084, "R6 raise and clear two lines");

    // pend0 = 0x80 ; new mask 0x04 gives pend0 = 0x04: rise and fall at once
    wr(8, 64'h04);
    chk("R8 post and drop together", {62'd0, cap_post[0], cap_drop[0]}, 64'b11);
    step(0, 0, 0, 3, 0, 1, 2, 0, 0);
    chk("R8 no post on re-raise", {60'd0, cap_post}, 0);

    step(1, 1, 9, 2'd2, 64'hFFFF, 0, 0, 0, 0);
    chk("R10 bad size err", {62'd0, cap_err, cap_rvalid}, 64'b10);
    rd(9, 64'h0F, "R10 mask1 unchanged");
    step(1, 1, 12, 2'd3, '1, 0, 0, 0, 0);
    chk("R11 write pending err", {63'd0, cap_err}, 1);
    rd(12, 64'h04, "R11 pending0 unchanged");
    step(1, 1, 16, 2'd3, 0, 0, 0, 0, 0);
    rd(16, 64'h8000_0000_0000_0084, "R11 request unchanged");
    step(1, 0, 40, 2'd3, 0, 0, 0, 0, 0);
    chk("R11 unmapped err", {62'd0, cap_err, cap_rvalid}, 64'b10);
    rd(0, 0, "R9 control/status zero");
    rd(3, 0, "R9 arbitration zero");

    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      step(op < 6, op < 3, int'($urandom_range(0, 18)),
           ($urandom_range(0, 15) == 0) ? 2'd1 : 2'd3,
           {$urandom, $urandom},
           $urandom_range(0, 2) == 0, int'($urandom_range(0, 63)),
           $urandom_range(0, 2) == 0, int'($urandom_range(0, 63)));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule